// File: doc/BRIEF.md
# Interrupt Coalescing Timer

This block merges bursts of completion events from a receive channel and a transmit channel into fewer interrupt requests. Each channel keeps a saturating count of its pending events. It raises its interrupt when that count reaches a programmed threshold, or when a programmed timeout runs out while at least one event is still pending, whichever comes first. The interrupt then stays high until software acknowledges it. The acknowledge clears the count and the timer along with the interrupt.

Timeouts are counted in timer units. A unit is a fixed number of bit times, with a normal length and a long length. A bit time is a parameterised number of system clocks in the fast link mode and a multiple of that in the slow link mode. With the defaults, a normal unit is 512 bit times and a long unit is 8192 bit times, and a bit time in slow mode is ten times longer than in fast mode.

Top module: `evt_coalesce`

## Requirements
- R1: After reset both interrupt outputs are low and both pending counts are zero.
- R2: With threshold T (1..7), the interrupt goes high on the clock edge that captures the event bringing the pending count to T. Events are single-cycle pulses, counted one per clock.
- R3: A threshold field of 0 behaves exactly like a threshold of 1.
- R4: With a timeout field N (1..15) and the count below the threshold, the interrupt goes high exactly N×U clock edges after the edge that captured the first pending event, where U is the clock length of one timer unit.
- R5: U = B × CLKS_PER_10NS × M. B is NORM_BITS when the long-unit select bit is 0 and LONG_BITS when it is 1. M is 1 when `fast_mode` is 1 and SLOW_MULT when it is 0.
- R6: A timeout field of 0 disables the timeout path. If the threshold is not reached, no interrupt is raised, however long the wait.
- R7: The timer does not advance while the pending count is zero, so a channel with no events never raises its interrupt.
- R8: An acknowledge clears that channel's count, timer and interrupt on the next edge. An event in the same cycle as the acknowledge is counted as the first event of the new round.
- R9: The interrupt stays high until acknowledged. The pending count saturates at 7 and does not wrap.
- R10: The channels are independent. `cfg_word[7:0]` configures receive and `cfg_word[15:8]` configures transmit. Within each byte, bits [2:0] are the threshold, bits [6:3] are the timeout and bit 7 is the long-unit select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Per-channel threshold, timeout and unit-length fields |
| fast_mode | input | 1 | 1 = fast link (short bit time), 0 = slow link |
| rx_event | input | 1 | Receive completion pulse |
| tx_event | input | 1 | Transmit completion pulse |
| rx_ack | input | 1 | Receive interrupt acknowledge |
| tx_ack | input | 1 | Transmit interrupt acknowledge |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with CLKS_PER_10NS=1, NORM_BITS=4, LONG_BITS=16 and SLOW_MULT=3. A timer unit is then 4, 16, 12 or 48 clocks. This brings all four unit lengths, and even the largest timeout of 15 long slow units (720 clocks), within an exact edge-by-edge comparison. With these values the bench can also set a threshold and a timeout against each other and confirm that the earlier of the two wins.

// File: rtl/coal_pkg.sv
package coal_pkg;

  localparam int THR_W = 3;
  localparam int TMO_W = 4;
  localparam int CH_CFG_W = THR_W + TMO_W + 1;
  localparam int N_CH = 2;

  // one byte of the configuration word
  typedef struct packed {
    logic             lng;
    logic [TMO_W-1:0] tmo;
    logic [THR_W-1:0] thr;
  } ch_cfg_t;

  // a zero threshold counts as one
  function automatic logic [THR_W-1:0] thr_eff(input logic [THR_W-1:0] thr);
    return (thr == '0) ? THR_W'(1) : thr;
  endfunction

  // clocks in one timer unit
  function automatic int unsigned unit_clks(input logic fast, input logic lng,
                                            input int unsigned c10,
                                            input int unsigned nbits,
                                            input int unsigned lbits,
                                            input int unsigned smul);
    int unsigned bits;
    int unsigned mul;
    bits = lng ? lbits : nbits;
    mul  = fast ? 1 : smul;
    return bits * c10 * mul;
  endfunction

endpackage

// File: rtl/coal_evt_counter.sv
module coal_evt_counter
  import coal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             ev,
  input  logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] cnt,
  output logic             thr_hit
);

  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0] cnt_q;
  logic [THR_W-1:0] cnt_nxt;

  always_comb begin
    if (ack)
      cnt_nxt = ev ? THR_W'(1) : '0;
    else if (ev && (cnt_q != CNT_MAX))
      cnt_nxt = cnt_q + THR_W'(1);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign thr_hit = (cnt_nxt >= thr_eff(thr));
  assign cnt     = cnt_q;

endmodule

// File: rtl/coal_unit_timer.sv
module coal_unit_timer
  import coal_pkg::*;
#(
  parameter int TW = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TW-1:0]    unit_len,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire
);

  localparam logic [TMO_W-1:0] UNITS_MAX = {TMO_W{1'b1}};

  logic [TW-1:0]    pre_q;
  logic [TMO_W-1:0] units_q;
  logic             unit_done;

  assign unit_done = run && (({1'b0, pre_q} + (TW+1)'(1)) >= {1'b0, unit_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (clr) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (unit_done) begin
      pre_q   <= '0;
      if (units_q != UNITS_MAX) units_q <= units_q + TMO_W'(1);
    end else if (run) begin
      pre_q   <= pre_q + TW'(1);
    end
  end

  assign expire = unit_done && (tmo != '0) &&
                  (({1'b0, units_q} + (TMO_W+1)'(1)) >= {1'b0, tmo});

endmodule

// File: rtl/coal_channel.sv
module coal_channel
  import coal_pkg::*;
#(
  parameter int CLKS_PER_10NS = 1,
  parameter int NORM_BITS     = 512,
  parameter int LONG_BITS     = 8192,
  parameter int SLOW_MULT     = 10,
  parameter int TW            = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             fast,
  input  logic             ev,
  input  logic             ack,
  output logic             irq,
  output logic [THR_W-1:0] cnt,
  output logic             thr_hit,
  output logic             tmo_hit
);

  logic          irq_q;
  logic          tmr_run;
  logic          tmr_expire;
  logic [TW-1:0] unit_len;

  assign unit_len = TW'(unit_clks(fast, cfg.lng, CLKS_PER_10NS, NORM_BITS,
                                  LONG_BITS, SLOW_MULT));

  coal_evt_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .ev      (ev),
    .thr     (cfg.thr),
    .cnt     (cnt),
    .thr_hit (thr_hit)
  );

  assign tmr_run = (cnt != '0) && !irq_q && !ack;

  coal_unit_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ack),
    .run      (tmr_run),
    .unit_len (unit_len),
    .tmo      (cfg.tmo),
    .expire   (tmr_expire)
  );

  assign tmo_hit = tmr_expire && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (ack) irq_q <= thr_hit;
    else          irq_q <= irq_q | thr_hit | tmo_hit;
  end

  assign irq = irq_q;

endmodule

// File: rtl/evt_coalesce.sv
module evt_coalesce
  import coal_pkg::*;
#(
  parameter int CLKS_PER_10NS = 1,
  parameter int NORM_BITS     = 512,
  parameter int LONG_BITS     = 8192,
  parameter int SLOW_MULT     = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CH*CH_CFG_W-1:0]  cfg_word,
  input  logic                      fast_mode,
  input  logic                      rx_event,
  input  logic                      tx_event,
  input  logic                      rx_ack,
  input  logic                      tx_ack,
  output logic                      rx_irq,
  output logic                      tx_irq
);

  localparam int MAX_UNIT = LONG_BITS * CLKS_PER_10NS * SLOW_MULT;
  localparam int TW       = $clog2(MAX_UNIT + 1);

  // index 0 = receive, 1 = transmit
  logic [N_CH-1:0]            ch_ev;
  logic [N_CH-1:0]            ch_ack;
  logic [N_CH-1:0]            ch_irq;
  logic [N_CH-1:0]            ch_thr_hit;
  logic [N_CH-1:0]            ch_tmo_hit;
  logic [N_CH-1:0][THR_W-1:0] ch_cnt;

  assign ch_ev  = {tx_event, rx_event};
  assign ch_ack = {tx_ack, rx_ack};

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ch_cfg_t ccfg;
    assign ccfg = ch_cfg_t'(cfg_word[i*CH_CFG_W +: CH_CFG_W]);

    coal_channel #(
      .CLKS_PER_10NS (CLKS_PER_10NS),
      .NORM_BITS     (NORM_BITS),
      .LONG_BITS     (LONG_BITS),
      .SLOW_MULT     (SLOW_MULT),
      .TW            (TW)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (ccfg),
      .fast    (fast_mode),
      .ev      (ch_ev[i]),
      .ack     (ch_ack[i]),
      .irq     (ch_irq[i]),
      .cnt     (ch_cnt[i]),
      .thr_hit (ch_thr_hit[i]),
      .tmo_hit (ch_tmo_hit[i])
    );
  end

  assign rx_irq = ch_irq[0];
  assign tx_irq = ch_irq[1];

endmodule

// File: rtl/evt_coalesce_chk.sv
module evt_coalesce_chk
  import coal_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_CH*CH_CFG_W-1:0]  cfg,
  input logic [N_CH-1:0]           ack,
  input logic [N_CH-1:0]           ev,
  input logic [N_CH-1:0]           irq,
  input logic [N_CH-1:0][THR_W-1:0] cnt,
  input logic [N_CH-1:0]           thr_hit,
  input logic [N_CH-1:0]           tmo_hit
);

  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    logic [TMO_W-1:0] tmo_f;
    assign tmo_f = cfg[i*CH_CFG_W + THR_W +: TMO_W];

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack[i] && !ev[i] |=> !irq[i] && (cnt[i] == '0));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !ack[i] |=> irq[i]);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == CNT_MAX) && !ack[i] |=> (cnt[i] == CNT_MAX));

    // R2
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[i] && !ack[i] && !thr_hit[i] && !tmo_hit[i] |=> !irq[i]);

    // R2
    thr_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit[i] |=> irq[i]);

    // R7
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == '0) |-> !tmo_hit[i]);

    // R6
    tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_f == '0) |-> !tmo_hit[i]);
  end

endmodule

bind evt_coalesce evt_coalesce_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg     (cfg_word),
  .ack     (ch_ack),
  .ev      (ch_ev),
  .irq     (ch_irq),
  .cnt     (ch_cnt),
  .thr_hit (ch_thr_hit),
  .tmo_hit (ch_tmo_hit)
);

// File: tb/evt_coalesce_bench.sv
`timescale 1ns/1ps
module evt_coalesce_bench;

  localparam int C10 = 1;
  localparam int NB  = 4;
  localparam int LB  = 16;
  localparam int SM  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = 16'h0101;
  logic        fast_mode = 1'b1;
  logic        rx_event = 1'b0, tx_event = 1'b0;
  logic        rx_ack = 1'b0, tx_ack = 1'b0;
  logic        rx_irq, tx_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  evt_coalesce #(.CLKS_PER_10NS(C10), .NORM_BITS(NB), .LONG_BITS(LB),
                 .SLOW_MULT(SM)) u_evt_coalesce (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .fast_mode(fast_mode),
    .rx_event(rx_event), .tx_event(tx_event), .rx_ack(rx_ack), .tx_ack(tx_ack),
    .rx_irq(rx_irq), .tx_irq(tx_irq));

  // vector: ch(1) thr(3) tmo(4) lng(1) fast(1) nev(4)
  localparam int NV = 12;
  localparam logic [13:0] VECS [NV] = '{
    {1'b0, 3'd1, 4'd0,  1'b0, 1'b1, 4'd1},
    {1'b1, 3'd3, 4'd0,  1'b0, 1'b1, 4'd5},
    {1'b0, 3'd0, 4'd0,  1'b0, 1'b1, 4'd1},
    {1'b1, 3'd7, 4'd0,  1'b0, 1'b1, 4'd7},
    {1'b0, 3'd4, 4'd2,  1'b0, 1'b1, 4'd1},
    {1'b1, 3'd4, 4'd3,  1'b1, 1'b1, 4'd2},
    {1'b0, 3'd6, 4'd2,  1'b0, 1'b0, 4'd1},
    {1'b1, 3'd5, 4'd1,  1'b1, 1'b0, 4'd3},
    {1'b0, 3'd5, 4'd0,  1'b0, 1'b1, 4'd2},
    {1'b1, 3'd3, 4'd5,  1'b0, 1'b1, 4'd0},
    {1'b0, 3'd2, 4'd15, 1'b1, 1'b0, 4'd3},
    {1'b0, 3'd7, 4'd15, 1'b1, 1'b0, 4'd1}
  };
  string TAGS [NV] = '{"R2", "R2", "R3", "R2", "R4", "R5",
                       "R5", "R5", "R6", "R7", "R4", "R5"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected edge of the interrupt, counted from the first event edge
  function automatic int expect_edge(int thr, int tmo, bit lng, bit fast, int nev);
    int t_edge, o_edge, unit;
    int need;
    need   = (thr < 1) ? 1 : thr;
    t_edge = (nev >= need) ? need - 1 : -1;
    unit   = (lng ? LB : NB) * C10;
    if (!fast) unit = unit * SM;
    o_edge = (tmo > 0 && nev > 0) ? tmo * unit : -1;
    if (t_edge < 0) return o_edge;
    if (o_edge < 0) return t_edge;
    return (t_edge < o_edge) ? t_edge : o_edge;
  endfunction

  task automatic ack_both();
    @(negedge clk);
    rx_ack = 1'b1; tx_ack = 1'b1; rx_event = 1'b0; tx_event = 1'b0;
    @(negedge clk);
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [13:0] v;
    bit ch, lng, fast;
    int thr, tmo, nev, exp, limit, first;
    bit other;
    logic [7:0] cc;
    v    = VECS[idx];
    ch   = v[13];
    thr  = int'(v[12:10]);
    tmo  = int'(v[9:6]);
    lng  = v[5];
    fast = v[4];
    nev  = int'(v[3:0]);
    exp  = expect_edge(thr, tmo, lng, fast, nev);
    limit = (exp >= 0) ? exp + 4 : 300;
    cc = {lng, v[9:6], v[12:10]};
    @(negedge clk);
    cfg_word  = ch ? {cc, 8'h01} : {8'h01, cc};
    fast_mode = fast;
    ack_both();
    first = -1;
    other = 1'b0;
    for (int k = 0; k < limit; k++) begin
      if (ch) tx_event = (k < nev); else rx_event = (k < nev);
      @(posedge clk);
      #1;
      if ((ch ? tx_irq : rx_irq) && first < 0) first = k;
      if (ch ? rx_irq : tx_irq) other = 1'b1;
      @(negedge clk);
    end
    rx_event = 1'b0; tx_event = 1'b0;
    check(first == exp, TAGS[idx], first, exp);
    // R10: the idle channel never fires
    check(other == 1'b0, "R10", int'(other), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(!rx_irq && !tx_irq, "R1", int'({tx_irq, rx_irq}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: sticky interrupt
    @(negedge clk);
    cfg_word = 16'h0101; fast_mode = 1'b1;
    ack_both();
    rx_event = 1'b1;
    @(negedge clk);
    rx_event = 1'b0;
    repeat (30) @(negedge clk);
    check(rx_irq == 1'b1, "R9", int'(rx_irq), 1);
    // R8: acknowledge drops it
    rx_ack = 1'b1;
    @(posedge clk); #1;
    check(rx_irq == 1'b0, "R8", int'(rx_irq), 0);
    @(negedge clk); rx_ack = 1'b0;

    // R8: event alongside acknowledge, threshold 2
    cfg_word = 16'h0102;
    @(negedge clk);
    rx_ack = 1'b1; rx_event = 1'b1;
    @(posedge clk); #1;
    check(rx_irq == 1'b0, "R8", int'(rx_irq), 0);
    @(negedge clk);
    rx_ack = 1'b0; rx_event = 1'b1;
    @(posedge clk); #1;
    check(rx_irq == 1'b1, "R8", int'(rx_irq), 1);
    @(negedge clk); rx_event = 1'b0;

    // R8: event alongside acknowledge, threshold 1 fires at once
    cfg_word = 16'h0101;
    rx_ack = 1'b1; rx_event = 1'b1;
    @(posedge clk); #1;
    check(rx_irq == 1'b1, "R8", int'(rx_irq), 1);
    @(negedge clk); rx_ack = 1'b0; rx_event = 1'b0;

    // R9: saturation, threshold 7 with 12 events
    cfg_word = 16'h0107;
    ack_both();
    for (int k = 0; k < 12; k++) begin
      rx_event = 1'b1;
      @(posedge clk); #1;
      if (k == 5) check(rx_irq == 1'b0, "R9", int'(rx_irq), 0);
      if (k == 6) check(rx_irq == 1'b1, "R9", int'(rx_irq), 1);
      @(negedge clk);
    end
    rx_event = 1'b0;
    repeat (5) @(negedge clk);
    check(rx_irq == 1'b1, "R9", int'(rx_irq), 1);
    // R8: count cleared, six new events stay below threshold
    ack_both();
    for (int k = 0; k < 6; k++) begin
      rx_event = 1'b1;
      @(negedge clk);
    end
    rx_event = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_irq == 1'b0, "R8", int'(rx_irq), 0);

    // R10: transmit fires while receive stays quiet with its own settings
    cfg_word = {8'h01, 8'h05};
    ack_both();
    tx_event = 1'b1; rx_event = 1'b1;
    @(posedge clk); #1;
    check(tx_irq == 1'b1 && rx_irq == 1'b0, "R10", int'({tx_irq, rx_irq}), 2);
    @(negedge clk); tx_event = 1'b0; rx_event = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule